// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers interrupt requests from one fast-interrupt input, a parameterised group of external request lines and a parameterised group of on-chip peripheral lines. It drives two active-low request outputs toward the processor: `nfiq_o` for the fast source alone and `nirq_o` for all other sources. The normal sources are arbitrated by a programmable 3-bit priority, so there are eight levels. A source already in service can only be preempted by a source of strictly higher priority.

Software sets up each source through a simple register port. Each source has its own word holding the priority, the trigger mode, the enable bit and a handler vector. When software reads the vector address, it gets the handler vector of the winning source and that source's level is marked as in service. If the request has gone away before the read, the read returns a programmable spurious vector instead. An end-of-interrupt write retires the highest level in service. In protect mode a vector read changes nothing, so a debugger can inspect the controller safely, and a write to the same address performs the acknowledge.

Sources are numbered as follows: 0 is the fast input, 1 to `N_EXT` are the external lines in bit order, and the peripheral lines follow in bit order. All request inputs are active high. Register reads are combinational from `addr_i`. Writes and read side effects take place at the rising clock edge where `wr_i` or `rd_i` is high.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset, `nirq_o` and `nfiq_o` are high. Every source word reads as zero, so all sources are masked. The spurious vector is zero, protect mode is off and no level is in service.
- R2: Among enabled pending normal sources (number 1 and up), the highest priority wins, where 7 is the highest and 0 the lowest. When priorities are equal, the lower source number wins.
- R3: A source whose enable bit (bit 4 of its word) is 0 never pulls `nirq_o` or `nfiq_o` low and is never returned as a vector.
- R4: `nirq_o` is low exactly when the winner's priority exceeds the highest level in service, or when the winner exists and no level is in service. A level-mode request reaches the output one clock after the input is sampled.
- R5: `nfiq_o` is low exactly when source 0 is enabled and pending, whatever the priorities and the levels in service. A read of address 0x21 returns the vector of source 0, or the spurious vector if source 0 is not active.
- R6: A read of address 0x20 returns the winner's vector in bits 15:0. When protect mode is off, the read also marks the winner's priority level as in service and clears its edge latch.
- R7: A vector read made while there is no winner returns the spurious vector. The spurious vector is written and read at address 0x23, bits 15:0. Such a read leaves the levels in service unchanged.
- R8: A write to address 0x22 retires the highest level in service. Lower levels that are still in service then again block sources of equal or lower priority.
- R9: When bit 3 of a source word is 1, the source is edge-triggered. A rising input edge is latched as pending two clocks after the edge is sampled, and it stays pending until it is acknowledged or cleared, even if the input has already fallen. When bit 3 is 0, the pending state follows the sampled input.
- R10: When bit 0 at address 0x25 is 1 (protect mode), a read of 0x20 or 0x21 leaves all state unchanged. A write to 0x20 or 0x21 then performs the acknowledge that the read would have performed.
- R11: A write to address 0x24 clears the edge latch of every source whose number matches a set bit of the written data.
- R12: Address n, for n below the source count, holds the word of source n. The word has priority in bits 2:0, edge mode in bit 3, enable in bit 4 and the vector in bits 23:8. The word reads back exactly as it was written, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fiq_i | input | 1 | Fast interrupt request (source 0) |
| ext_irq_i | input | N_EXT | External request lines (sources 1..N_EXT) |
| per_irq_i | input | N_PER | Peripheral request lines (following sources) |
| addr_i | input | 6 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (triggers read side effects) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| nirq_o | output | 1 | Normal interrupt request, active low |
| nfiq_o | output | 1 | Fast interrupt request, active low |

## Verification
The hardest situation to reach is a pending source that is blocked only by nesting. This means a source that is enabled and requesting, but whose priority equals or is below a level still in service. The same state must then be unwound by end-of-interrupt writes in the right order. The directed part of the bench builds this on purpose. It raises two sources of equal priority and acknowledges one, then retires levels one at a time. It also withdraws a request between the output falling and the vector read. A long random phase then mixes request toggles with reads, acknowledges, mode changes and reprogramming of the source words. A behavioural model built on a queue of levels in service follows both outputs and every read result on each clock.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam int unsigned PRIO_W = 3;
   localparam int unsigned NLEV   = 1 << PRIO_W;
   localparam int unsigned VEC_W  = 16;
   localparam int unsigned ADDR_W = 6;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_IVR  = 6'h20;
   localparam logic [ADDR_W-1:0] A_FVR  = 6'h21;
   localparam logic [ADDR_W-1:0] A_EOI  = 6'h22;
   localparam logic [ADDR_W-1:0] A_SPU  = 6'h23;
   localparam logic [ADDR_W-1:0] A_CLR  = 6'h24;
   localparam logic [ADDR_W-1:0] A_PROT = 6'h25;

   typedef struct packed {
      logic [VEC_W-1:0]  vec;
      logic              en;
      logic              edge_m;
      logic [PRIO_W-1:0] prio;
   } src_cfg_t;

   function automatic src_cfg_t unpack_cfg(logic [DATA_W-1:0] d);
      src_cfg_t c;
      c.prio   = d[PRIO_W-1:0];
      c.edge_m = d[3];
      c.en     = d[4];
      c.vec    = d[8 +: VEC_W];
      return c;
   endfunction

   function automatic logic [DATA_W-1:0] pack_cfg(src_cfg_t c);
      return DATA_W'({c.vec, 3'b000, c.en, c.edge_m, c.prio});
   endfunction

endpackage

// File: rtl/vic_src_cond.sv
module vic_src_cond (
   input  logic clk,
   input  logic rst,
   input  logic irq_i,
   input  logic edge_m_i,
   input  logic ack_i,
   input  logic clr_i,
   output logic pend_o
);

   logic samp_q, prev_q, latch_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         samp_q  <= 1'b0;
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         samp_q <= irq_i;
         prev_q <= samp_q;
         if (samp_q && !prev_q)
            latch_q <= 1'b1;
         else if (ack_i || clr_i)
            latch_q <= 1'b0;
      end
   end

   assign pend_o = edge_m_i ? latch_q : samp_q;

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
   import vic_pkg::*;
#(
   parameter int unsigned N_SRC = 8,
   parameter int unsigned IDX_W = 3
)(
   input  logic [N_SRC-1:0]             req_i,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [NLEV-1:0]              lvl_i,
   output logic                         win_valid_o,
   output logic [IDX_W-1:0]             win_idx_o,
   output logic [PRIO_W-1:0]            win_prio_o
);

   logic              best_v, top_v;
   logic [IDX_W-1:0]  best_i;
   logic [PRIO_W-1:0] best_p, top_l;

   // descending scan with >= lets the lowest index win a tie
   always_comb begin
      best_v = 1'b0;
      best_i = '0;
      best_p = '0;
      for (int i = N_SRC - 1; i >= 1; i--) begin
         if (req_i[i] && (!best_v || prio_i[i] >= best_p)) begin
            best_v = 1'b1;
            best_i = IDX_W'(i);
            best_p = prio_i[i];
         end
      end
   end

   always_comb begin
      top_v = 1'b0;
      top_l = '0;
      for (int l = 0; l < int'(NLEV); l++) begin
         if (lvl_i[l]) begin
            top_v = 1'b1;
            top_l = PRIO_W'(l);
         end
      end
   end

   assign win_valid_o = best_v && (!top_v || best_p > top_l);
   assign win_idx_o   = best_i;
   assign win_prio_o  = best_p;

endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
   import vic_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_lvl_i,
   input  logic              pop_i,
   output logic [NLEV-1:0]   lvl_o
);

   logic [NLEV-1:0] lvl_q, top_mask, lvl_nxt;

   always_comb begin
      top_mask = '0;
      for (int l = 0; l < int'(NLEV); l++) begin
         if (lvl_q[l]) begin
            top_mask    = '0;
            top_mask[l] = 1'b1;
         end
      end
      lvl_nxt = lvl_q;
      if (pop_i)  lvl_nxt = lvl_nxt & ~top_mask;
      if (push_i) lvl_nxt[push_lvl_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= '0;
      else     lvl_q <= lvl_nxt;
   end

   assign lvl_o = lvl_q;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned N_EXT = 3,
   parameter int unsigned N_PER = 4
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              fiq_i,
   input  logic [N_EXT-1:0]  ext_irq_i,
   input  logic [N_PER-1:0]  per_irq_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              nirq_o,
   output logic              nfiq_o
);

   localparam int unsigned N_SRC = 1 + N_EXT + N_PER;
   localparam int unsigned IDX_W = $clog2(N_SRC);

   if (N_SRC > 32) begin : g_bad_count
      $error("irq_vec_ctrl: at most 32 sources fit the address map and clear mask");
   end
   if (N_EXT < 1 || N_PER < 1) begin : g_bad_groups
      $error("irq_vec_ctrl: each source group needs at least one line");
   end

   src_cfg_t                    cfg_q [N_SRC];
   logic [VEC_W-1:0]            spur_q;
   logic                        prot_q;
   logic [N_SRC-1:0]            raw, pend, req, ack_vec, clr_vec;
   logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
   logic [NLEV-1:0]             lvl;
   logic                        win_valid, fiq_act, ack_irq, ack_fiq, eoi;
   logic [IDX_W-1:0]            win_idx;
   logic [PRIO_W-1:0]           win_prio;
   logic                        hit_ivr, hit_fvr;

   assign raw = {per_irq_i, ext_irq_i, fiq_i};

   assign hit_ivr = (addr_i == A_IVR);
   assign hit_fvr = (addr_i == A_FVR);
   assign ack_irq = win_valid && ((rd_i && hit_ivr && !prot_q) || (wr_i && hit_ivr && prot_q));
   assign ack_fiq = (rd_i && hit_fvr && !prot_q) || (wr_i && hit_fvr && prot_q);
   assign eoi     = wr_i && (addr_i == A_EOI);
   assign clr_vec = (wr_i && addr_i == A_CLR) ? wdata_i[N_SRC-1:0] : '0;
   assign fiq_act = pend[0] && cfg_q[0].en;

   always_comb begin
      ack_vec    = '0;
      ack_vec[0] = ack_fiq;
      if (ack_irq) ack_vec[win_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < int'(N_SRC); s++) cfg_q[s] <= '0;
         spur_q <= '0;
         prot_q <= 1'b0;
      end else if (wr_i) begin
         for (int s = 0; s < int'(N_SRC); s++)
            if (addr_i == ADDR_W'(s)) cfg_q[s] <= unpack_cfg(wdata_i);
         if (addr_i == A_SPU)  spur_q <= wdata_i[VEC_W-1:0];
         if (addr_i == A_PROT) prot_q <= wdata_i[0];
      end
   end

   for (genvar g = 0; g < int'(N_SRC); g++) begin : g_src
      vic_src_cond u_cond (
         .clk      (clk),
         .rst      (rst),
         .irq_i    (raw[g]),
         .edge_m_i (cfg_q[g].edge_m),
         .ack_i    (ack_vec[g]),
         .clr_i    (clr_vec[g]),
         .pend_o   (pend[g])
      );
      assign req[g]      = pend[g] && cfg_q[g].en;
      assign prio_vec[g] = cfg_q[g].prio;
   end

   vic_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
      .req_i       (req),
      .prio_i      (prio_vec),
      .lvl_i       (lvl),
      .win_valid_o (win_valid),
      .win_idx_o   (win_idx),
      .win_prio_o  (win_prio)
   );

   vic_level_stack u_stack (
      .clk        (clk),
      .rst        (rst),
      .push_i     (ack_irq),
      .push_lvl_i (win_prio),
      .pop_i      (eoi),
      .lvl_o      (lvl)
   );

   always_comb begin
      rdata_o = '0;
      if (hit_ivr)
         rdata_o[VEC_W-1:0] = win_valid ? cfg_q[win_idx].vec : spur_q;
      else if (hit_fvr)
         rdata_o[VEC_W-1:0] = fiq_act ? cfg_q[0].vec : spur_q;
      else if (addr_i == A_SPU)
         rdata_o[VEC_W-1:0] = spur_q;
      else if (addr_i == A_PROT)
         rdata_o[0] = prot_q;
      else if (addr_i < ADDR_W'(N_SRC))
         rdata_o = pack_cfg(cfg_q[addr_i[IDX_W-1:0]]);
   end

   assign nirq_o = ~win_valid;
   assign nfiq_o = ~fiq_act;

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
   import vic_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic              rd_i,
   input logic              wr_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              nirq_o,
   input logic              nfiq_o,
   input logic              prot_q,
   input logic              fast_en,
   input logic              ack_irq,
   input logic              eoi,
   input logic [NLEV-1:0]   lvl
);

   logic rst_d;
   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst_d && !rst)
         p_idle_after_reset_r1: assert (nirq_o && nfiq_o);
   end

   p_fast_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
      !nfiq_o |-> fast_en);

   p_ack_pushes_level_r8: assert property (@(posedge clk) disable iff (rst)
      (ack_irq && !eoi) |=> ($countones(lvl) == $countones($past(lvl)) + 1));

   p_eoi_pops_level_r8: assert property (@(posedge clk) disable iff (rst)
      (eoi && !ack_irq && lvl != '0) |=> ($countones(lvl) + 1 == $countones($past(lvl))));

   p_protect_read_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      (prot_q && rd_i && !wr_i && addr_i == A_IVR) |=> $stable(lvl));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .rd_i    (rd_i),
   .wr_i    (wr_i),
   .addr_i  (addr_i),
   .nirq_o  (nirq_o),
   .nfiq_o  (nfiq_o),
   .prot_q  (prot_q),
   .fast_en (cfg_q[0].en),
   .ack_irq (ack_irq),
   .eoi     (eoi),
   .lvl     (lvl)
);

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
   import vic_pkg::*;

   localparam int NE = 3;
   localparam int NP = 4;
   localparam int NS = 1 + NE + NP;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              fiq = 1'b0;
   logic [NE-1:0]     ext = '0;
   logic [NP-1:0]     per = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr = 1'b0, rd = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              nirq, nfiq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_vec_ctrl #(.N_EXT(NE), .N_PER(NP)) dut_i (
      .clk(clk), .rst(rst), .fiq_i(fiq), .ext_irq_i(ext), .per_irq_i(per),
      .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
      .nirq_o(nirq), .nfiq_o(nfiq)
   );

   // ---------------- behavioural reference ----------------
   int m_samp[NS], m_prev[NS], m_latch[NS];
   int m_prio[NS], m_em[NS], m_en[NS], m_vec[NS];
   int m_spur, m_prot;
   int m_lv[$];
   bit started = 0;

   function automatic int m_pend(int i);
      return (m_em[i] != 0) ? m_latch[i] : m_samp[i];
   endfunction

   function automatic int m_winner();
      int bi;
      int top;
      bi  = -1;
      top = (m_lv.size() > 0) ? m_lv[m_lv.size()-1] : -1;
      for (int i = 1; i < NS; i++)
         if (m_pend(i) != 0 && m_en[i] != 0 && (bi < 0 || m_prio[i] > m_prio[bi])) bi = i;
      if (bi >= 0 && m_prio[bi] <= top) bi = -1;
      return bi;
   endfunction

   function automatic int m_fast();
      return (m_pend(0) != 0 && m_en[0] != 0) ? 1 : 0;
   endfunction

   function automatic logic [31:0] m_rdata(logic [ADDR_W-1:0] a);
      int w;
      w = m_winner();
      if (a == A_IVR)  return (w >= 0) ? m_vec[w] : m_spur;
      if (a == A_FVR)  return (m_fast() != 0) ? m_vec[0] : m_spur;
      if (a == A_SPU)  return m_spur;
      if (a == A_PROT) return m_prot;
      if (int'(a) < NS)
         return (m_vec[a] << 8) | (m_en[a] << 4) | (m_em[a] << 3) | m_prio[a];
      return 0;
   endfunction

   function automatic logic src_bit(int i);
      if (i == 0) return fiq;
      if (i <= NE) return ext[i-1];
      return per[i-1-NE];
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         started = 1;
         for (int i = 0; i < NS; i++) begin
            m_samp[i] = 0; m_prev[i] = 0; m_latch[i] = 0;
            m_prio[i] = 0; m_em[i] = 0; m_en[i] = 0; m_vec[i] = 0;
         end
         m_spur = 0; m_prot = 0;
         m_lv.delete();
      end else begin
         int w;
         bit a_irq, a_fiq;
         w = m_winner();
         a_irq = (w >= 0) && ((rd && addr == A_IVR && m_prot == 0) || (wr && addr == A_IVR && m_prot != 0));
         a_fiq = (rd && addr == A_FVR && m_prot == 0) || (wr && addr == A_FVR && m_prot != 0);
         for (int i = 0; i < NS; i++) begin
            bit ack_i, clr_i;
            ack_i = (i == 0) ? a_fiq : (a_irq && w == i);
            clr_i = wr && addr == A_CLR && wdata[i];
            if (m_samp[i] != 0 && m_prev[i] == 0) m_latch[i] = 1;
            else if (ack_i || clr_i) m_latch[i] = 0;
            m_prev[i] = m_samp[i];
            m_samp[i] = src_bit(i);
         end
         if (eoi_now() && m_lv.size() > 0) void'(m_lv.pop_back());
         if (a_irq) m_lv.push_back(m_prio[w]);
         if (wr && int'(addr) < NS) begin
            m_prio[addr] = wdata[2:0];
            m_em[addr]   = wdata[3];
            m_en[addr]   = wdata[4];
            m_vec[addr]  = wdata[23:8];
         end
         if (wr && addr == A_SPU)  m_spur = wdata[15:0];
         if (wr && addr == A_PROT) m_prot = wdata[0];
      end
   end

   function automatic bit eoi_now();
      return wr && addr == A_EOI;
   endfunction

   // ---------------- checking ----------------
   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !rst && !done) begin
         chk("R4", "nirq vs model", {31'b0, nirq}, (m_winner() >= 0) ? 32'd0 : 32'd1);
         chk("R5", "nfiq vs model", {31'b0, nfiq}, (m_fast() != 0) ? 32'd0 : 32'd1);
         if (rd) chk("R6", "rdata vs model", rdata, m_rdata(addr));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic bus_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk); #1;
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk); #1;
      rd = 1'b1; addr = a;
      #2 d = rdata;
      @(negedge clk); #1;
      rd = 1'b0;
   endtask

   function automatic logic [31:0] cw(int p, int e, int en, int v);
      return (v << 8) | (en << 4) | (e << 3) | p;
   endfunction

   // ---------------- test sequence ----------------
   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      rst = 1'b0;
      step(1);

      chk("R1", "nirq after reset", {31'b0, nirq}, 1);
      chk("R1", "nfiq after reset", {31'b0, nfiq}, 1);
      bus_rd(6'd1, d);
      chk("R1", "source word after reset", d, 0);
      bus_rd(A_IVR, d);
      chk("R7", "spurious vector after reset", d, 0);

      bus_wr(A_SPU, 32'hDEAD);
      bus_wr(6'd1, cw(2, 0, 1, 16'h0100));
      bus_wr(6'd2, cw(5, 0, 1, 16'h0200));
      bus_wr(6'd3, cw(7, 0, 0, 16'h0300));
      bus_wr(6'd4, cw(5, 0, 1, 16'h0400));
      bus_rd(6'd2, d);
      chk("R12", "source word readback", d, cw(5, 0, 1, 16'h0200));

      ext[2] = 1'b1;                 // source 3, masked
      step(3);
      chk("R3", "masked source keeps nirq high", {31'b0, nirq}, 1);

      ext[0] = 1'b1;                 // source 1, prio 2
      step(2);
      chk("R4", "level request lowers nirq", {31'b0, nirq}, 0);
      bus_rd(A_IVR, d);
      chk("R6", "vector of source 1", d, 32'h0100);
      chk("R8", "nirq high while level 2 in service", {31'b0, nirq}, 1);

      ext[1] = 1'b1; per[0] = 1'b1;  // sources 2 and 4, both prio 5
      step(2);
      chk("R8", "higher priority preempts", {31'b0, nirq}, 0);
      bus_rd(A_IVR, d);
      chk("R2", "tie goes to lower source number", d, 32'h0200);
      chk("R8", "equal priority does not preempt", {31'b0, nirq}, 1);

      ext[1] = 1'b0;
      step(2);
      bus_wr(A_EOI, 0);
      chk("R8", "after retiring 5 source 4 requests", {31'b0, nirq}, 0);
      bus_rd(A_IVR, d);
      chk("R2", "vector of source 4", d, 32'h0400);
      bus_wr(A_EOI, 0);
      bus_wr(A_EOI, 0);
      per[0] = 1'b0; ext[0] = 1'b0;
      step(2);
      chk("R4", "no request leaves nirq high", {31'b0, nirq}, 1);

      ext[0] = 1'b1;
      step(2);
      chk("R4", "request before withdrawal", {31'b0, nirq}, 0);
      ext[0] = 1'b0;
      step(2);
      bus_rd(A_IVR, d);
      chk("R7", "withdrawn request gives spurious", d, 32'hDEAD);
      ext[0] = 1'b1;
      step(2);
      chk("R7", "spurious read pushed no level", {31'b0, nirq}, 0);
      ext[0] = 1'b0;
      step(2);

      bus_wr(6'd5, cw(3, 1, 1, 16'h0500));
      per[1] = 1'b1; step(1); per[1] = 1'b0;
      step(3);
      chk("R9", "edge latched after pulse", {31'b0, nirq}, 0);
      bus_rd(A_IVR, d);
      chk("R9", "vector of edge source", d, 32'h0500);
      bus_wr(A_EOI, 0);
      chk("R9", "acknowledge cleared edge latch", {31'b0, nirq}, 1);

      per[1] = 1'b1; step(1); per[1] = 1'b0;
      step(3);
      chk("R9", "second edge latched", {31'b0, nirq}, 0);
      bus_wr(A_CLR, 32'h20);
      chk("R11", "clear write drops latch", {31'b0, nirq}, 1);

      bus_wr(A_PROT, 1);
      per[1] = 1'b1; step(1); per[1] = 1'b0;
      step(3);
      bus_rd(A_IVR, d);
      chk("R10", "protected read returns vector", d, 32'h0500);
      chk("R10", "protected read leaves request", {31'b0, nirq}, 0);
      bus_wr(A_IVR, 0);
      chk("R10", "write acknowledges in protect mode", {31'b0, nirq}, 1);
      bus_wr(A_EOI, 0);
      chk("R10", "latch gone after write acknowledge", {31'b0, nirq}, 1);
      bus_wr(A_PROT, 0);

      bus_wr(6'd0, cw(0, 0, 1, 16'h0F00));
      fiq = 1'b1;
      step(2);
      chk("R5", "fast request lowers nfiq", {31'b0, nfiq}, 0);
      bus_rd(A_FVR, d);
      chk("R5", "fast vector", d, 32'h0F00);
      fiq = 1'b0;
      step(2);
      chk("R5", "fast release raises nfiq", {31'b0, nfiq}, 1);

      for (int it = 0; it < 4000; it++) begin
         int op;
         @(negedge clk); #1;
         rd = 1'b0; wr = 1'b0; wdata = '0;
         if ($urandom_range(0, 3) == 0) ext = NE'($urandom);
         if ($urandom_range(0, 3) == 0) per = NP'($urandom);
         if ($urandom_range(0, 5) == 0) fiq = ~fiq;
         op = $urandom_range(0, 99);
         if (op < 22) begin rd = 1'b1; addr = A_IVR; end
         else if (op < 36) begin wr = 1'b1; addr = A_EOI; end
         else if (op < 41) begin rd = 1'b1; addr = A_FVR; end
         else if (op < 51) begin
            wr = 1'b1; addr = ADDR_W'($urandom_range(0, NS-1));
            wdata = cw($urandom_range(0, 7), $urandom_range(0, 1),
                       ($urandom_range(0, 3) != 0) ? 1 : 0, $urandom_range(0, 65535));
         end
         else if (op < 55) begin wr = 1'b1; addr = A_CLR; wdata = $urandom; end
         else if (op < 58) begin wr = 1'b1; addr = A_PROT; wdata = ($urandom_range(0, 2) == 0) ? 1 : 0; end
         else if (op < 63) begin wr = 1'b1; addr = A_IVR; end
         else if (op < 68) begin rd = 1'b1; addr = ADDR_W'($urandom_range(0, NS-1)); end
         else if (op < 70) begin wr = 1'b1; addr = A_SPU; wdata = $urandom; end
      end
      @(negedge clk); #1;
      rd = 1'b0; wr = 1'b0;
      step(2);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule